// File: doc/BRIEF.md
# Adaptive Pulse-Skip Overcurrent Guard

This block holds the digital fault logic behind the peak current protection of a buck converter. At every switching cycle start it decides whether the power switch may conduct. If it may, it ignores the raw current comparator for a programmable number of system clocks so that switching noise cannot trip it, and then samples the comparator exactly once. An overcurrent seen at that sample cuts the gate for the rest of the cycle.

What follows depends on whether the converter is still ramping up. While soft-start is running, each repeated fault makes the block skip one more of the following switching cycles, up to a ceiling. Each clean sample lowers that count by one again, so the load current settles near the limit. Once the output is in regulation, a fault instead raises a hiccup request to the soft-start sequencer. That request holds the reference at zero and keeps the switch off for a fixed number of switching cycles, after which soft-start runs again. With a hard short the converter therefore alternates between hiccup and constant-current operation, and at the ceiling of seven it conducts in only one cycle out of eight.

Top module: `ocp_pulse_guard`

## Requirements
- R1: After reset, gate_en, gate_off and hiccup_req are 0 and skip_level is 0.
- R2: In a conducting cycle, oc_raw is ignored for MASK_CLKS clocks after the cycle-start edge. It is sampled once, at the (MASK_CLKS+1)-th rising edge after that start edge.
- R3: When the sample finds oc_raw=1, gate_off is 1 from the clock after the sample until the next cycle start. gate_en stays 1 for the rest of that cycle.
- R4: When softstart_on=1 and the sample finds oc_raw=1, skip_level rises by one, saturating at MAX_SKIP (7 by default). The next skip_level cycle starts are then skipped: gate_en stays 0, gate_off stays 0 and oc_raw is not sampled. At saturation, one cycle in eight conducts.
- R5: A sample that finds oc_raw=0 lowers skip_level by one, never below 0. This happens at most once per switching cycle.
- R6: When softstart_on=0 and the sample finds oc_raw=1, hiccup_req goes to 1 and skip_level to 0. The next HICCUP_CYC cycle starts do not conduct (gate_en=0). hiccup_req returns to 0 after the last of them.
- R7: A cycle start that arrives before the sample restarts the masking interval. The comparator value of the abandoned cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock pulse at each switching cycle start |
| oc_raw | input | 1 | Raw peak-current comparator, 1 = above limit |
| softstart_on | input | 1 | 1 while the soft-start ramp is running |
| gate_en | output | 1 | 1 when the current switching cycle may conduct |
| gate_off | output | 1 | 1 when the switch is cut for the rest of this cycle |
| hiccup_req | output | 1 | Level request to hold the reference at zero |
| skip_level | output | $clog2(MAX_SKIP+1) | Current adaptive skip count |

## Verification
The assertions take for granted that cyc_start is a single-clock pulse and that switching cycles are longer than MASK_CLKS+1 clocks. R7 is the only exception, where a start arrives on purpose before the sample. They also take softstart_on to be stable within a cycle. The stimulus drives every input on the falling clock edge, raises cyc_start for exactly one clock, and changes softstart_on only together with a cycle start. It makes every normal cycle MASK_CLKS+4 clocks long. The one deliberately shortened cycle places its restart one clock before the sample would have been taken.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  // Saturating step up of the adaptive skip count.
  function automatic int unsigned skip_step_up(input int unsigned cur, input int unsigned cap);
    return (cur >= cap) ? cap : cur + 1;
  endfunction

  // Floored step down of the adaptive skip count.
  function automatic int unsigned skip_step_down(input int unsigned cur);
    return (cur == 0) ? 0 : cur - 1;
  endfunction

endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int unsigned MASK_CLKS = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic conduct_start,
  output logic samp_evt
);
  localparam int unsigned MW = $clog2(MASK_CLKS + 1);

  logic [MW-1:0] mask_cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_cnt <= '0;
      armed    <= 1'b0;
    end else if (conduct_start) begin
      mask_cnt <= MW'(MASK_CLKS);
      armed    <= 1'b1;
    end else if (cyc_start) begin
      armed    <= 1'b0;
    end else if (armed) begin
      if (mask_cnt != '0) mask_cnt <= mask_cnt - 1'b1;
      else                armed    <= 1'b0;
    end
  end

  assign samp_evt = armed && (mask_cnt == '0);

  AST_BLANK_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    conduct_start |=> !samp_evt); // R2

endmodule

// File: rtl/ocp_skip_tracker.sv
module ocp_skip_tracker #(
  parameter int unsigned MAX_SKIP = 7,
  parameter int unsigned CW       = $clog2(MAX_SKIP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_hit,
  input  logic          clean_hit,
  input  logic          skip_take,
  input  logic          clear,
  output logic [CW-1:0] skip_cnt,
  output logic          skipping
);
  logic [CW-1:0] skip_left;
  logic [CW-1:0] cnt_up;
  logic [CW-1:0] cnt_dn;

  always_comb begin
    cnt_up = CW'(ocp_pkg::skip_step_up(32'(skip_cnt), MAX_SKIP));
    cnt_dn = CW'(ocp_pkg::skip_step_down(32'(skip_cnt)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_cnt  <= '0;
      skip_left <= '0;
    end else if (clear) begin
      skip_cnt  <= '0;
      skip_left <= '0;
    end else if (soft_hit) begin
      skip_cnt  <= cnt_up;
      skip_left <= cnt_up;
    end else if (clean_hit) begin
      skip_cnt  <= cnt_dn;
    end else if (skip_take && skip_left != '0) begin
      skip_left <= skip_left - 1'b1;
    end
  end

  assign skipping = (skip_left != '0);

  AST_SKIP_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_hit && skip_cnt == CW'(MAX_SKIP)) |=> skip_cnt == CW'(MAX_SKIP)); // R4
  AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    skip_left <= skip_cnt); // R4
  AST_CLEAN_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    clean_hit |=> skip_cnt <= $past(skip_cnt)); // R5

endmodule

// File: rtl/ocp_hiccup_timer.sv
module ocp_hiccup_timer #(
  parameter int unsigned HICCUP_CYC = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  input  logic cyc_tick,
  output logic busy
);
  localparam int unsigned HW = $clog2(HICCUP_CYC + 1);

  logic [HW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       left <= '0;
    else if (trigger)                 left <= HW'(HICCUP_CYC);
    else if (cyc_tick && left != '0)  left <= left - 1'b1;
  end

  assign busy = (left != '0);

  AST_HICCUP_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !trigger) |=> !busy); // R6

endmodule

// File: rtl/ocp_pulse_guard.sv
module ocp_pulse_guard #(
  parameter int unsigned MASK_CLKS  = 40,
  parameter int unsigned MAX_SKIP   = 7,
  parameter int unsigned HICCUP_CYC = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic oc_raw,
  input  logic softstart_on,
  output logic gate_en,
  output logic gate_off,
  output logic hiccup_req,
  output logic [$clog2(MAX_SKIP+1)-1:0] skip_level
);
  localparam int unsigned SKW = $clog2(MAX_SKIP + 1);

  // Named internal events
  logic hic_busy, skipping, samp_evt;
  logic conduct_start, skip_take, hic_take;
  logic sample_fire, oc_hit, clean_hit, soft_hit, reg_hit;
  logic conducting, cut;

  assign conduct_start = cyc_start && !hic_busy && !skipping;
  assign skip_take     = cyc_start && !hic_busy &&  skipping;
  assign hic_take      = cyc_start &&  hic_busy;
  assign sample_fire   = samp_evt && !cyc_start;
  assign oc_hit        = sample_fire &&  oc_raw;
  assign clean_hit     = sample_fire && !oc_raw;
  assign soft_hit      = oc_hit &&  softstart_on;
  assign reg_hit       = oc_hit && !softstart_on;

  ocp_blank_timer #(.MASK_CLKS(MASK_CLKS)) u_blank (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
    .conduct_start(conduct_start), .samp_evt(samp_evt)
  );

  ocp_skip_tracker #(.MAX_SKIP(MAX_SKIP), .CW(SKW)) u_skip (
    .clk(clk), .rst_n(rst_n), .soft_hit(soft_hit), .clean_hit(clean_hit),
    .skip_take(skip_take), .clear(reg_hit), .skip_cnt(skip_level),
    .skipping(skipping)
  );

  ocp_hiccup_timer #(.HICCUP_CYC(HICCUP_CYC)) u_hiccup (
    .clk(clk), .rst_n(rst_n), .trigger(reg_hit), .cyc_tick(hic_take),
    .busy(hic_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conducting <= 1'b0;
      cut        <= 1'b0;
    end else if (cyc_start) begin
      conducting <= conduct_start;
      cut        <= 1'b0;
    end else if (oc_hit) begin
      cut        <= 1'b1;
    end
  end

  assign gate_en    = conducting;
  assign gate_off   = cut;
  assign hiccup_req = hic_busy;

  AST_CUT_ONLY_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_off) |-> $past(samp_evt)); // R3
  AST_SKIP_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    skip_take |=> !gate_en && !gate_off); // R4
  AST_HICCUP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    reg_hit |=> hiccup_req && skip_level == '0); // R6
  AST_HICCUP_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    hic_take |=> !gate_en); // R6
  AST_RESTART_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && samp_evt) |=> !gate_off); // R7

endmodule

// File: tb/ocp_pulse_guard_test.sv
`timescale 1ns/1ps
module ocp_pulse_guard_test;
  localparam int MASK = 3;
  localparam int MAXS = 7;
  localparam int HIC  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 1'b0, oc_raw = 1'b0, softstart_on = 1'b0;
  logic gate_en, gate_off, hiccup_req;
  logic [2:0] skip_level;

  int checks = 0, errors = 0, cycles = 0;
  int m_cnt = 0, m_left = 0, m_hic = 0, m_cond = 0;
  int seen_en = 0;

  ocp_pulse_guard #(.MASK_CLKS(MASK), .MAX_SKIP(MAXS), .HICCUP_CYC(HIC)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .oc_raw(oc_raw),
    .softstart_on(softstart_on), .gate_en(gate_en), .gate_off(gate_off),
    .hiccup_req(hiccup_req), .skip_level(skip_level)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Model: decision taken at a cycle-start edge
  task automatic model_start();
    if (m_hic > 0) begin m_hic = m_hic - 1; m_cond = 0; end
    else if (m_left > 0) begin m_left = m_left - 1; m_cond = 0; end
    else m_cond = 1;
  endtask

  // Model: effect of a sample
  task automatic model_sample(input bit oc, input bit ss);
    if (m_cond == 0) return;
    if (oc) begin
      if (ss) begin m_cnt = (m_cnt >= MAXS) ? MAXS : m_cnt + 1; m_left = m_cnt; end
      else begin m_hic = HIC; m_cnt = 0; m_left = 0; end
    end else begin
      m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
    end
  endtask

  // One normal switching cycle of MASK+4 clocks
  task automatic do_cycle(input bit oc_blank, input bit oc_samp, input bit ss, input string req);
    @(negedge clk);
    cyc_start = 1'b1; oc_raw = oc_blank; softstart_on = ss;
    model_start();
    @(negedge clk);
    cyc_start = 1'b0;
    seen_en = seen_en + int'(gate_en);
    chk(req, "gate_en after start", int'(gate_en), m_cond);
    chk(req, "gate_off after start", int'(gate_off), 0);
    repeat (MASK) @(negedge clk);
    oc_raw = oc_samp;
    @(negedge clk);
    oc_raw = 1'b0;
    model_sample(oc_samp, ss);
    chk(req, "gate_off after sample", int'(gate_off), (m_cond != 0 && oc_samp) ? 1 : 0);
    chk(req, "skip_level", int'(skip_level), m_cnt);
    chk(req, "hiccup_req", int'(hiccup_req), (m_hic != 0) ? 1 : 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "gate_en", int'(gate_en), 0);
    chk("R1", "gate_off", int'(gate_off), 0);
    chk("R1", "hiccup_req", int'(hiccup_req), 0);
    chk("R1", "skip_level", int'(skip_level), 0);
    rst_n = 1'b1;

    // R2: comparator high only during blanking is ignored
    do_cycle(1'b1, 1'b0, 1'b1, "R2");
    do_cycle(1'b1, 1'b0, 1'b0, "R2");
    // R3: comparator high only at the sample cuts the gate (soft-start)
    do_cycle(1'b0, 1'b1, 1'b1, "R3");
    chk("R3", "gate_en kept", int'(gate_en), 1);
    // R5: clean cycles walk down, floor at zero
    for (int i = 0; i < 4; i++) do_cycle(1'b0, 1'b0, 1'b1, "R5");

    // R4: repeated soft-start faults climb to saturation (skipped cycles in between)
    for (int i = 0; i < 40; i++) do_cycle(1'b1, 1'b1, 1'b1, "R4");
    chk("R4", "saturated level", int'(skip_level), MAXS);
    // R4: at saturation one cycle in eight conducts
    seen_en = 0;
    for (int i = 0; i < 32; i++) do_cycle(1'b1, 1'b1, 1'b1, "R4");
    chk("R4", "conducting cycles in 32", seen_en, 4);

    // R5: clean conducting cycles lower the level back to zero
    for (int i = 0; i < 20; i++) do_cycle(1'b0, 1'b0, 1'b1, "R5");
    chk("R5", "level back at zero", int'(skip_level), 0);

    // Partial climb, then regulation fault starting from a nonzero level
    for (int i = 0; i < 4; i++) do_cycle(1'b0, 1'b1, 1'b1, "R4");
    // R6: regulation faults produce hiccup, then alternate
    for (int i = 0; i < 30; i++) do_cycle(1'b1, 1'b1, 1'b0, "R6");
    for (int i = 0; i < HIC + 2; i++) do_cycle(1'b0, 1'b0, 1'b0, "R6");
    chk("R6", "hiccup released", int'(hiccup_req), 0);

    // R7: restart before the sample; the comparator high of the short cycle is dropped
    @(negedge clk);
    cyc_start = 1'b1; oc_raw = 1'b1; softstart_on = 1'b1;
    model_start();
    @(negedge clk);
    cyc_start = 1'b0;
    chk("R7", "short cycle gate_en", int'(gate_en), m_cond);
    repeat (MASK - 1) begin
      chk("R7", "short cycle gate_off", int'(gate_off), 0);
      @(negedge clk);
    end
    cyc_start = 1'b1;
    model_start();
    @(negedge clk);
    cyc_start = 1'b0;
    chk("R7", "restart gate_off", int'(gate_off), 0);
    repeat (MASK) @(negedge clk);
    oc_raw = 1'b0;
    @(negedge clk);
    model_sample(1'b0, 1'b1);
    chk("R7", "gate_off at new sample", int'(gate_off), 0);
    chk("R7", "skip_level", int'(skip_level), m_cnt);
    do_cycle(1'b0, 1'b1, 1'b1, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule